// File: doc/BRIEF.md
# Event-Word Readout Buffer with Toggle Test

This block collects event words from upstream signal processors, stores them in a first-in first-out buffer of 32-bit entries, and hands them on over two paths. Each event word is assembled inside the block from its fields (stop and start markers, two 10-bit samples, a 4-bit event number and a channel number) with an even parity bit on top. A streaming output link drains the buffer with a valid/ready handshake. A 16-bit host port reads either a status word or one half of the oldest entry.

A small control register written by the host picks what a host read returns and how the output link behaves. In the normal mode the link carries the stored words. In the toggle test mode the link still drains the buffer, but every word it sends is replaced by a pattern that alternates between all zeros and all ones, so the output lines switch at full load. In the hold mode the link stays idle and the buffer is left for the host to read.

The input side uses valid/ready: `in_ready` is high while the buffer has room, and a beat is taken on a cycle with both high. A beat offered while `in_ready` is low is not held for a retry: it is dropped and recorded. On the output side, `link_valid` never waits for `link_ready`; the word and `link_valid` stay steady while `link_ready` is low, unless a host data read takes the same entry.

Top module: `evword_readout`

## Requirements
- R1: In normal mode the link word is {parity, 0, stop, start, down[9:0], event[3:0], up[9:0], channel[3:0]} from bit 31 down to bit 0, where parity makes the count of ones in bits 31..0 even.
- R2: Entries leave in the order they were accepted; `in_ready` is low exactly while the buffer holds DEPTH entries.
- R3: An input beat offered while the buffer is full is dropped and sets an overflow flag that stays set until reset; the flag is bit 1 of the status word.
- R4: The control register is written with `host_wr`: bit 0 selects data reads, bit 1 the high half, bit 2 toggle mode, bit 3 hold mode; reset value 0. A read with bit 0 clear returns the status word (bit 0 empty, bit 1 overflow, other bits zero) one cycle after `host_rd` and removes nothing.
- R5: A data read with bit 1 clear returns bits 15..0 of the oldest entry one cycle after `host_rd`.
- R6: A data read with bit 1 set returns bits 31..16; every data read removes the whole entry, so the next read refers to the following entry.
- R7: A data read while the buffer is empty returns zero and removes nothing.
- R8: Outside hold mode, `link_valid` is high whenever the buffer is not empty and no host data read occurs in that cycle; an entry leaves on a cycle with `link_valid` and `link_ready` high, and the word holds while `link_ready` is low.
- R9: In toggle mode (bit 2 set, bit 3 clear) each link beat drains one entry but carries all zeros or all ones, starting with all zeros after a control write and alternating on each accepted beat.
- R10: In toggle mode no pattern is offered once the buffer is empty.
- R11: With bit 3 set, `link_valid` stays low and the entries stay in the buffer.
- R12: A host data read in the same cycle as a waiting link beat takes the entry; `link_valid` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Buffer has room |
| in_stop | input | 1 | Stop marker |
| in_start | input | 1 | Start marker |
| in_down | input | 10 | Sample from the lower processors |
| in_event | input | 4 | Event number |
| in_up | input | 10 | Sample from the upper processors |
| in_chan | input | 4 | Channel number, 0 to 12 |
| host_wr | input | 1 | Write strobe for the control register |
| host_wctl | input | 4 | Control value |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 16 | Read result, valid the cycle after `host_rd` |
| link_valid | output | 1 | Output word offered |
| link_ready | input | 1 | Output link accepts |
| link_data | output | 32 | Output word |

## Verification
The link outputs and `in_ready` depend on the current buffer state and on `host_rd` in the same cycle, so they are compared a little after the falling edge, with no register in between. `host_rdata` passes through one register, so it is compared just after the rising edge that follows the strobe, and its expected value is formed from the model state before that edge. A control write takes effect on the next cycle, and the model applies pops, pushes and control writes in the order the edge does, so a word or pattern change is due exactly one cycle after the beat that caused it.

// File: rtl/evword_pkg.sv
package evword_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef struct packed {
    logic       stop;
    logic       start;
    logic [9:0] down;
    logic [3:0] evnum;
    logic [9:0] up;
    logic [3:0] chan;
  } ev_fields_t;

  typedef struct packed {
    logic d_pre;
    logic c_toggle;
    logic b_high;
    logic a_data;
  } ctrl_t;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_TOGGLE = 2'd1,
    MODE_HOLD   = 2'd2
  } link_mode_e;
endpackage

// File: rtl/evword_pack.sv
module evword_pack
  import evword_pkg::*;
(
  input  ev_fields_t        fields,
  output logic [WORD_W-1:0] word
);
  logic parity;

  // bit 30 is a constant zero, so parity over the fields covers bits 30..0
  always_comb begin
    parity = ^fields;
    word   = {parity, 1'b0, fields};
  end
endmodule

// File: rtl/evword_fifo.sv
module evword_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/evword_linkmux.sv
module evword_linkmux
  import evword_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  link_mode_e       mode,
  input  logic             clr_phase,
  input  logic             fifo_empty,
  input  logic             host_busy,
  input  logic [WIDTH-1:0] head,
  input  logic             link_ready,
  output logic             link_valid,
  output logic [WIDTH-1:0] link_data,
  output logic             link_pop
);
  logic phase;

  always_comb begin
    link_valid = (mode != MODE_HOLD) && !fifo_empty && !host_busy;
    link_data  = (mode == MODE_TOGGLE) ? {WIDTH{phase}} : head;
    link_pop   = link_valid && link_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              phase <= 1'b0;
    else if (clr_phase)                      phase <= 1'b0;
    else if (link_pop && mode == MODE_TOGGLE) phase <= ~phase;
  end
endmodule

// File: rtl/evword_readout.sv
module evword_readout
  import evword_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_stop,
  input  logic        in_start,
  input  logic [9:0]  in_down,
  input  logic [3:0]  in_event,
  input  logic [9:0]  in_up,
  input  logic [3:0]  in_chan,
  input  logic        host_wr,
  input  logic [3:0]  host_wctl,
  input  logic        host_rd,
  output logic [15:0] host_rdata,
  output logic        link_valid,
  input  logic        link_ready,
  output logic [31:0] link_data
);
  ctrl_t             ctrl;
  ev_fields_t        fields;
  link_mode_e        mode;
  logic [WORD_W-1:0] packed_word, head;
  logic              fifo_empty, fifo_full;
  logic              host_busy, host_pop, link_pop;
  logic              overflow_q;
  logic [HALF_W-1:0] rd_next;

  assign fields = '{stop: in_stop, start: in_start, down: in_down,
                    evnum: in_event, up: in_up, chan: in_chan};

  evword_pack u_pack (.fields(fields), .word(packed_word));

  assign in_ready  = !fifo_full;
  assign host_busy = host_rd && ctrl.a_data;
  assign host_pop  = host_busy && !fifo_empty;

  evword_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid && in_ready), .din(packed_word),
    .pop(host_pop || link_pop), .dout(head),
    .empty(fifo_empty), .full(fifo_full)
  );

  always_comb begin
    if (ctrl.d_pre)         mode = MODE_HOLD;
    else if (ctrl.c_toggle) mode = MODE_TOGGLE;
    else                    mode = MODE_NORMAL;
  end

  evword_linkmux #(.WIDTH(WORD_W)) u_link (
    .clk(clk), .rst_n(rst_n), .mode(mode), .clr_phase(host_wr),
    .fifo_empty(fifo_empty), .host_busy(host_busy), .head(head),
    .link_ready(link_ready), .link_valid(link_valid),
    .link_data(link_data), .link_pop(link_pop)
  );

  always_comb begin
    if (!ctrl.a_data)   rd_next = {14'b0, overflow_q, fifo_empty};
    else if (fifo_empty) rd_next = '0;
    else if (ctrl.b_high) rd_next = head[WORD_W-1:HALF_W];
    else                 rd_next = head[HALF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl       <= '0;
      overflow_q <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (host_wr)               ctrl       <= ctrl_t'(host_wctl);
      if (in_valid && fifo_full) overflow_q <= 1'b1;
      if (host_rd)               host_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/evword_readout_chk.sv
module evword_readout_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_rd,
  input logic        host_wr,
  input logic [15:0] host_rdata,
  input logic        link_valid,
  input logic        link_ready,
  input logic [31:0] link_data,
  input logic        sel_data,
  input logic        toggle_mode,
  input logic        pre_mode,
  input logic        fifo_empty,
  input logic        overflow
);
  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_status_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !sel_data) |=> (host_rdata[15:2] == '0 && host_rdata[0] == $past(fifo_empty)));

  p_empty_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && sel_data && fifo_empty) |=> (host_rdata == '0));

  p_link_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd && $past(link_valid && !link_ready && !host_rd && !host_wr))
      |-> (link_valid && $stable(link_data)));

  p_toggle_pattern_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && toggle_mode && !pre_mode) |-> (link_data == '0 || &link_data));

  p_hold_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pre_mode |-> !link_valid);

  p_host_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && sel_data) |-> !link_valid);
endmodule

bind evword_readout evword_readout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
  .host_rdata(host_rdata), .link_valid(link_valid), .link_ready(link_ready),
  .link_data(link_data), .sel_data(ctrl.a_data), .toggle_mode(ctrl.c_toggle),
  .pre_mode(ctrl.d_pre), .fifo_empty(fifo_empty), .overflow(overflow_q)
);

// File: tb/evword_readout_test.sv
module evword_readout_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        in_valid = 0, in_stop = 0, in_start = 0;
  logic [9:0]  in_down = 0, in_up = 0;
  logic [3:0]  in_event = 0, in_chan = 0, host_wctl = 0;
  logic        host_wr = 0, host_rd = 0, link_ready = 0;
  logic        in_ready, link_valid;
  logic [15:0] host_rdata;
  logic [31:0] link_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] q[$];
  logic [3:0]  m_ctrl = 0;
  logic        m_phase = 0, m_ovf = 0;
  logic [15:0] m_rd = 0;
  string       m_rd_tag = "R4 reset read value";

  evword_readout #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_stop(in_stop), .in_start(in_start), .in_down(in_down),
    .in_event(in_event), .in_up(in_up), .in_chan(in_chan),
    .host_wr(host_wr), .host_wctl(host_wctl), .host_rd(host_rd),
    .host_rdata(host_rdata), .link_valid(link_valid),
    .link_ready(link_ready), .link_data(link_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    int ones;
    w = 32'(in_chan) | (32'(in_up) << 4) | (32'(in_event) << 14)
      | (32'(in_down) << 18) | (32'(in_start) << 28) | (32'(in_stop) << 29);
    ones = 0;
    for (int i = 0; i < 31; i++) if (w[i]) ones++;
    if (ones % 2 == 1) w[31] = 1'b1;
    return w;
  endfunction

  task automatic step();
    int sz;
    bit hd, lv, tog, hold;
    logic [31:0] w;
    string vtag;
    #1;
    sz   = q.size();
    hold = m_ctrl[3];
    tog  = !m_ctrl[3] && m_ctrl[2];
    hd   = host_rd && m_ctrl[0];
    lv   = !hold && sz > 0 && !hd;
    chk("R2 in_ready", 32'(in_ready), 32'(sz < DEPTH));
    if (hold)                vtag = "R11 link_valid in hold";
    else if (hd)             vtag = "R12 link_valid during host read";
    else if (tog && sz == 0) vtag = "R10 link_valid toggle empty";
    else                     vtag = "R8 link_valid";
    chk(vtag, 32'(link_valid), 32'(lv));
    if (lv) chk(tog ? "R9 toggle pattern" : "R1 link word", link_data,
                tog ? {32{m_phase}} : q[0]);
    if (host_rd) begin
      if (!m_ctrl[0]) begin
        m_rd = {14'b0, m_ovf, 1'(sz == 0)};
        m_rd_tag = m_ovf ? "R3 status overflow" : "R4 status read";
      end else if (sz == 0) begin
        m_rd = 16'h0;
        m_rd_tag = "R7 read when empty";
      end else begin
        m_rd = m_ctrl[1] ? q[0][31:16] : q[0][15:0];
        m_rd_tag = m_ctrl[1] ? "R6 high half pop" : "R5 low half";
      end
    end
    w = model_word();
    if (hd && sz > 0) void'(q.pop_front());
    else if (lv && link_ready) begin
      void'(q.pop_front());
      if (tog) m_phase = !m_phase;
    end
    if (in_valid) begin
      if (sz < DEPTH) q.push_back(w);
      else m_ovf = 1'b1;
    end
    if (host_wr) begin
      m_ctrl = host_wctl;
      m_phase = 1'b0;
    end
    @(posedge clk);
    #1;
    chk(m_rd_tag, 32'(host_rdata), 32'(m_rd));
    @(negedge clk);
  endtask

  task automatic cyc(bit iv, int s, bit rd, bit wr, logic [3:0] wd, bit lr);
    in_valid   = iv;
    in_stop    = s[0];
    in_start   = s[1];
    in_down    = 10'((s * 37 + 3) % 1024);
    in_event   = 4'(s % 16);
    in_up      = 10'((s * 91 + 5) % 1024);
    in_chan    = 4'(s % 13);
    host_rd    = rd;
    host_wr    = wr;
    host_wctl  = wd;
    link_ready = lr;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state: all checks run in the first step
    cyc(0, 0, 0, 0, 4'h0, 1);
    // hold mode, host access (R4, R5, R6, R7, R11)
    cyc(0, 0, 0, 1, 4'h8, 1);
    for (int i = 0; i < 3; i++) cyc(1, i + 1, 0, 0, 4'h0, 1);
    cyc(0, 0, 1, 0, 4'h0, 1);
    cyc(0, 0, 0, 1, 4'h9, 1);
    cyc(0, 0, 1, 0, 4'h0, 1);
    cyc(0, 0, 0, 1, 4'hB, 1);
    cyc(0, 0, 1, 0, 4'h0, 1);
    cyc(0, 0, 1, 0, 4'h0, 1);
    cyc(0, 0, 1, 0, 4'h0, 1);
    cyc(0, 0, 0, 1, 4'h8, 1);
    cyc(0, 0, 1, 0, 4'h0, 1);
    // fill past capacity (R2, R3)
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, 40 + i * 7, 0, 0, 4'h0, 1);
    cyc(0, 0, 1, 0, 4'h0, 1);
    // normal draining with stalls and fresh pushes (R1, R8)
    cyc(0, 0, 0, 1, 4'h0, 0);
    for (int i = 0; i < 24; i++) cyc(i % 4 == 1, 200 + i, 0, 0, 4'h0, i % 3 != 0);
    // host reads competing with the link (R12)
    for (int i = 0; i < 4; i++) cyc(1, 300 + i, 0, 0, 4'h0, 0);
    cyc(0, 0, 0, 1, 4'h1, 0);
    cyc(0, 0, 1, 0, 4'h0, 1);
    cyc(0, 0, 1, 0, 4'h0, 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 4'h0, 1);
    cyc(0, 0, 1, 0, 4'h0, 1);
    // toggle mode (R9, R10)
    cyc(0, 0, 0, 1, 4'h4, 0);
    for (int i = 0; i < 6; i++) cyc(1, 400 + i, 0, 0, 4'h0, 0);
    for (int i = 0; i < 5; i++) cyc(i == 2, 500 + i, 0, 0, 4'h0, i % 2 == 0);
    cyc(0, 0, 0, 1, 4'h4, 1);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 4'h0, 1);
    cyc(0, 0, 0, 1, 4'h0, 1);
    cyc(0, 0, 1, 0, 4'h0, 1);
    cyc(0, 0, 0, 0, 4'h0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule